// File: doc/BRIEF.md
# Parallel I/O pin bank

This block manages a bank of up to 32 general-purpose pads from a small word-addressed register bus. Each pad has one bit in every control vector. For every pad the block decides who drives it: the bank's own output latch, or one of two internal peripheral functions, called the primary and the alternate function. It also holds the direction, the output level, the pull-up enable, the open-drain mode and an optional input glitch filter for each pad.

Software never writes a control vector directly. Each vector has a set strobe address and a clear strobe address. A 1 in the written word sets or clears the matching bit, and a 0 leaves that bit as it is. A third address reads the vector back. A separate read-only address returns the sampled level of every pad, whoever owns the pad. The same sampled level goes to the peripherals and to an interrupt block outside this bank through `pin_level`.

Top module: `pio_bank`

## Requirements
- R1: After reset, every pad belongs to the bank's own logic (ownership status reads all ones) and is an input with its driver off (direction status 0, `pad_oe` 0). Pull-ups are on (status and `pad_pu` all ones). Open-drain, filter, output data and function selection all read 0.
- R2: Each control vector has a base address: ownership 0x00, direction 0x10, filter 0x20, output data 0x30, open-drain 0x40, pull-up 0x50, function select 0x60. A write to base+0x0 sets the bits written as 1, a write to base+0x4 clears them, and base+0x8 reads the vector. Bits written as 0 keep their value. The writes take effect at the clock edge of the write.
- R3: A pad with ownership bit 1 and open-drain bit 0 drives `pad_out` from its output data bit and `pad_oe` from its direction bit.
- R4: A pad with ownership bit 0 is driven by a peripheral. Function-select bit 0 picks the primary function (`per_a_out`/`per_a_oe`) and bit 1 picks the alternate function (`per_b_out`/`per_b_oe`). The vector at 0x60 is set by writing 0x60 (selects alternate) and cleared by writing 0x64 (selects primary).
- R5: With the open-drain bit set, a pad never drives high. `pad_out` is 0, and `pad_oe` is 1 only when the selected source enables its output and its data bit is 0.
- R6: `pad_pu` equals the pull-up vector.
- R7: Address 0x70 and `pin_level` report the level of every pad, whether or not the bank owns it. With the filter bit off, a change on `pad_in` appears there after the second rising clock edge.
- R8: With the filter bit on, a pad change is accepted only after two consecutive samples agree. A step appears after the third rising edge, and a pulse that lasts a single sample never appears.
- R9: Set and clear strobe addresses, unaligned addresses and unused addresses read 0. A write to a status address or to 0x70 changes no control vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data, one bit per pad |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| pad_in | input | 32 | Level seen at each pad |
| pad_out | output | 32 | Value driven to each pad |
| pad_oe | output | 32 | Driver enable for each pad |
| pad_pu | output | 32 | Pull-up enable for each pad |
| pin_level | output | 32 | Sampled and optionally filtered pad level |
| per_a_out | input | 32 | Primary function output data |
| per_a_oe | input | 32 | Primary function output enable |
| per_b_out | input | 32 | Alternate function output data |
| per_b_oe | input | 32 | Alternate function output enable |

## Verification
The checker watches every cycle. It confirms that set and clear strobes touch exactly the written bits, that writes to status addresses leave the vectors alone, and that open-drain pads never drive high. It also compares the pad outputs with the selected source for bank-owned pads and for pads on the alternate function, and checks that the pull-up output follows its vector. Some behaviour can only be shown by the bench's timed scenarios. These are the reset values seen over the bus, the exact edge on which a pad change reaches the level register, the rejection of a single-sample pulse by the filter, and zero reads from strobe and unused addresses.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int unsigned PIO_BUS_W  = 32;
   localparam int unsigned PIO_NCFG   = 7;
   localparam int unsigned PIO_STRIDE = 16;
   // vector indices; base address = index * PIO_STRIDE
   localparam int unsigned CFG_OWN  = 0;
   localparam int unsigned CFG_DIR  = 1;
   localparam int unsigned CFG_FILT = 2;
   localparam int unsigned CFG_DATA = 3;
   localparam int unsigned CFG_OD   = 4;
   localparam int unsigned CFG_PU   = 5;
   localparam int unsigned CFG_SEL  = 6;
   localparam int unsigned OFS_SET  = 0;
   localparam int unsigned OFS_CLR  = 4;
   localparam int unsigned OFS_STAT = 8;
   localparam int unsigned OFS_LEVEL = PIO_NCFG * PIO_STRIDE;

   function automatic bit cfg_resets_high(int unsigned idx);
      return (idx == CFG_OWN) || (idx == CFG_PU);
   endfunction

   function automatic int unsigned cfg_addr(int unsigned idx, int unsigned ofs);
      return idx * PIO_STRIDE + ofs;
   endfunction
endpackage

// File: rtl/pio_setclr_reg.sv
module pio_setclr_reg #(
   parameter int unsigned W        = 32,
   parameter bit          RST_ONES = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] RST_VAL = RST_ONES ? {W{1'b1}} : {W{1'b0}};

   logic [W-1:0] set_m;
   logic [W-1:0] clr_m;

   always_comb begin
      set_m = set_en ? wmask : '0;
      clr_m = clr_en ? wmask : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= (q | set_m) & ~clr_m;
   end
endmodule

// File: rtl/pio_in_filter.sv
module pio_in_filter #(
   parameter int unsigned NPINS      = 32,
   parameter bit          HAS_FILTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] filt_en,
   input  logic [NPINS-1:0] pad_in,
   output logic [NPINS-1:0] level
);
   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic smp_now;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) smp_now <= 1'b0;
         else        smp_now <= pad_in[p];
      end

      if (HAS_FILTER) begin : g_filt
         logic smp_prev;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               smp_prev <= 1'b0;
               level[p] <= 1'b0;
            end else begin
               smp_prev <= smp_now;
               if (!filt_en[p] || (smp_now == smp_prev)) level[p] <= smp_now;
            end
         end
      end else begin : g_raw
         logic unused_en;
         assign unused_en = filt_en[p];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level[p] <= 1'b0;
            else        level[p] <= smp_now;
         end
      end
   end
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
   parameter int unsigned NPINS     = 32,
   parameter bit          HAS_OPEN_DRAIN = 1'b1
) (
   input  logic [NPINS-1:0] own_io,
   input  logic [NPINS-1:0] sel_alt,
   input  logic [NPINS-1:0] od_en,
   input  logic [NPINS-1:0] io_out,
   input  logic [NPINS-1:0] io_oe,
   input  logic [NPINS-1:0] pa_out,
   input  logic [NPINS-1:0] pa_oe,
   input  logic [NPINS-1:0] pb_out,
   input  logic [NPINS-1:0] pb_oe,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);
   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      logic src_out;
      logic src_oe;
      always_comb begin
         if (own_io[p]) begin
            src_out = io_out[p];
            src_oe  = io_oe[p];
         end else if (sel_alt[p]) begin
            src_out = pb_out[p];
            src_oe  = pb_oe[p];
         end else begin
            src_out = pa_out[p];
            src_oe  = pa_oe[p];
         end
      end

      if (HAS_OPEN_DRAIN) begin : g_od
         always_comb begin
            if (od_en[p]) begin
               pad_out[p] = 1'b0;
               pad_oe[p]  = src_oe & ~src_out;
            end else begin
               pad_out[p] = src_out;
               pad_oe[p]  = src_oe;
            end
         end
      end else begin : g_push
         logic unused_od;
         assign unused_od  = od_en[p];
         assign pad_out[p] = src_out;
         assign pad_oe[p]  = src_oe;
      end
   end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_pkg::*;
#(
   parameter int unsigned NPINS          = 32,
   parameter int unsigned AW             = 8,
   parameter bit          HAS_FILTER     = 1'b1,
   parameter bit          HAS_OPEN_DRAIN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [AW-1:0]        bus_addr,
   input  logic [PIO_BUS_W-1:0] bus_wdata,
   output logic [PIO_BUS_W-1:0] bus_rdata,
   input  logic [NPINS-1:0]     pad_in,
   output logic [NPINS-1:0]     pad_out,
   output logic [NPINS-1:0]     pad_oe,
   output logic [NPINS-1:0]     pad_pu,
   output logic [NPINS-1:0]     pin_level,
   input  logic [NPINS-1:0]     per_a_out,
   input  logic [NPINS-1:0]     per_a_oe,
   input  logic [NPINS-1:0]     per_b_out,
   input  logic [NPINS-1:0]     per_b_oe
);
   localparam int unsigned MAP_BYTES = OFS_LEVEL + 4;

   if (NPINS < 1 || NPINS > PIO_BUS_W) begin : g_bad_npins
      $error("pio_bank: NPINS must lie in 1..32");
   end
   if ((1 << AW) < MAP_BYTES) begin : g_bad_aw
      $error("pio_bank: AW too narrow for the register map");
   end

   logic [NPINS-1:0] cfg_q [PIO_NCFG];
   logic [NPINS-1:0] cfg_ioen, cfg_oe, cfg_filt, cfg_data, cfg_md, cfg_pu, cfg_absel;

   for (genvar g = 0; g < PIO_NCFG; g++) begin : g_cfg
      logic hit_set, hit_clr;
      assign hit_set = bus_wr && (bus_addr == AW'(cfg_addr(g, OFS_SET)));
      assign hit_clr = bus_wr && (bus_addr == AW'(cfg_addr(g, OFS_CLR)));
      pio_setclr_reg #(.W(NPINS), .RST_ONES(cfg_resets_high(g))) u_vec (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_en (hit_set),
         .clr_en (hit_clr),
         .wmask  (bus_wdata[NPINS-1:0]),
         .q      (cfg_q[g])
      );
   end

   assign cfg_ioen  = cfg_q[CFG_OWN];
   assign cfg_oe    = cfg_q[CFG_DIR];
   assign cfg_filt  = cfg_q[CFG_FILT];
   assign cfg_data  = cfg_q[CFG_DATA];
   assign cfg_md    = cfg_q[CFG_OD];
   assign cfg_pu    = cfg_q[CFG_PU];
   assign cfg_absel = cfg_q[CFG_SEL];

   pio_in_filter #(.NPINS(NPINS), .HAS_FILTER(HAS_FILTER)) u_filter (
      .clk     (clk),
      .rst_n   (rst_n),
      .filt_en (cfg_filt),
      .pad_in  (pad_in),
      .level   (pin_level)
   );

   pio_pad_mux #(.NPINS(NPINS), .HAS_OPEN_DRAIN(HAS_OPEN_DRAIN)) u_mux (
      .own_io  (cfg_ioen),
      .sel_alt (cfg_absel),
      .od_en   (cfg_md),
      .io_out  (cfg_data),
      .io_oe   (cfg_oe),
      .pa_out  (per_a_out),
      .pa_oe   (per_a_oe),
      .pb_out  (per_b_out),
      .pb_oe   (per_b_oe),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   assign pad_pu = cfg_pu;

   always_comb begin
      bus_rdata = '0;
      for (int k = 0; k < PIO_NCFG; k++) begin
         if (bus_addr == AW'(cfg_addr(k, OFS_STAT))) bus_rdata[NPINS-1:0] = cfg_q[k];
      end
      if (bus_addr == AW'(OFS_LEVEL)) bus_rdata[NPINS-1:0] = pin_level;
   end
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk
   import pio_pkg::*;
#(
   parameter int unsigned NPINS = 32,
   parameter int unsigned AW    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic [AW-1:0]        bus_addr,
   input logic [PIO_BUS_W-1:0] bus_wdata,
   input logic [NPINS-1:0]     pad_out,
   input logic [NPINS-1:0]     pad_oe,
   input logic [NPINS-1:0]     pad_pu,
   input logic [NPINS-1:0]     per_b_out,
   input logic [NPINS-1:0]     per_b_oe,
   input logic [NPINS-1:0]     cfg_ioen,
   input logic [NPINS-1:0]     cfg_oe,
   input logic [NPINS-1:0]     cfg_data,
   input logic [NPINS-1:0]     cfg_md,
   input logic [NPINS-1:0]     cfg_pu,
   input logic [NPINS-1:0]     cfg_absel
);
   logic [NPINS-1:0] wm;
   logic wr_dir_set, wr_own_clr, wr_dir_stat;
   assign wm          = bus_wdata[NPINS-1:0];
   assign wr_dir_set  = bus_wr && (bus_addr == AW'(cfg_addr(CFG_DIR, OFS_SET)));
   assign wr_own_clr  = bus_wr && (bus_addr == AW'(cfg_addr(CFG_OWN, OFS_CLR)));
   assign wr_dir_stat = bus_wr && (bus_addr == AW'(cfg_addr(CFG_DIR, OFS_STAT)));

   AST_SET_WRITTEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_set |=> ((cfg_oe & $past(wm)) == $past(wm))); // R2
   AST_SET_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_set |=> (((cfg_oe ^ $past(cfg_oe)) & ~$past(wm)) == '0)); // R2
   AST_CLR_WRITTEN_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_own_clr |=> ((cfg_ioen & $past(wm)) == '0)); // R2
   AST_STATUS_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir_stat |=> $stable(cfg_oe)); // R9
   AST_IO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((((pad_out ^ cfg_data) | (pad_oe ^ cfg_oe)) & cfg_ioen & ~cfg_md) == '0)); // R3
   AST_ALT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((((pad_out ^ per_b_out) | (pad_oe ^ per_b_oe)) & ~cfg_ioen & cfg_absel & ~cfg_md) == '0)); // R4
   AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & cfg_md) == '0)); // R5
   AST_PULLUP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu == cfg_pu)); // R6
endmodule

bind pio_bank pio_bank_chk #(.NPINS(NPINS), .AW(AW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .pad_pu    (pad_pu),
   .per_b_out (per_b_out),
   .per_b_oe  (per_b_oe),
   .cfg_ioen  (cfg_ioen),
   .cfg_oe    (cfg_oe),
   .cfg_data  (cfg_data),
   .cfg_md    (cfg_md),
   .cfg_pu    (cfg_pu),
   .cfg_absel (cfg_absel)
);

// File: tb/test_pio_bank.sv
module test_pio_bank;
   localparam logic [7:0] A_OWN_CLR = 8'h04, A_OWN_ST = 8'h08;
   localparam logic [7:0] A_DIR_SET = 8'h10, A_DIR_CLR = 8'h14, A_DIR_ST = 8'h18;
   localparam logic [7:0] A_FLT_SET = 8'h20, A_FLT_CLR = 8'h24, A_FLT_ST = 8'h28;
   localparam logic [7:0] A_DAT_SET = 8'h30, A_DAT_ST = 8'h38;
   localparam logic [7:0] A_OD_SET = 8'h40, A_OD_CLR = 8'h44, A_OD_ST = 8'h48;
   localparam logic [7:0] A_PU_SET = 8'h50, A_PU_CLR = 8'h54, A_PU_ST = 8'h58;
   localparam logic [7:0] A_ALT = 8'h60, A_PRI = 8'h64, A_SEL_ST = 8'h68;
   localparam logic [7:0] A_LVL = 8'h70;
   localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_PU = 3, K_LVL = 4;

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, pad_pu, pin_level;
   logic [31:0] per_a_out = 32'h1234_5678, per_a_oe = 32'hFFFF_0000;
   logic [31:0] per_b_out = 32'h9ABC_DEF0, per_b_oe = 32'h0000_FFFF;

   item_t sb_q[$];
   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;

   always #10 clk = ~clk;

   pio_bank i_pio_bank (
      .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .pad_in, .pad_out, .pad_oe, .pad_pu, .pin_level,
      .per_a_out, .per_a_oe, .per_b_out, .per_b_oe
   );

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   endtask

   // monitor: pops expected items and compares with the observed port
   initial begin
      forever begin
         item_t it;
         logic [31:0] act;
         wait (sb_q.size() > 0);
         #2;
         it = sb_q[0];
         case (it.kind)
            K_RD:    act = bus_rdata;
            K_OUT:   act = pad_out;
            K_OE:    act = pad_oe;
            K_PU:    act = pad_pu;
            default: act = pin_level;
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h (kind %0d)", it.req, act, it.exp, it.kind);
         end
         void'(sb_q.pop_front());
      end
   end

   task automatic expect_port(int kind, logic [31:0] exp, string req);
      item_t it;
      it.kind = kind; it.exp = exp; it.req = req;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic expect_read(logic [7:0] a, logic [31:0] exp, string req);
      bus_addr = a;
      expect_port(K_RD, exp, req);
   endtask

   task automatic bus_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      expect_read(A_OWN_ST, 32'hFFFF_FFFF, "R1");
      expect_read(A_DIR_ST, 32'h0, "R1");
      expect_read(A_PU_ST,  32'hFFFF_FFFF, "R1");
      expect_read(A_OD_ST,  32'h0, "R1");
      expect_read(A_FLT_ST, 32'h0, "R1");
      expect_read(A_DAT_ST, 32'h0, "R1");
      expect_read(A_SEL_ST, 32'h0, "R1");
      expect_port(K_OE, 32'h0, "R1");
      expect_port(K_PU, 32'hFFFF_FFFF, "R1");
      // R2 set/clear semantics
      bus_write(A_DIR_SET, 32'h0000_00FF);
      expect_read(A_DIR_ST, 32'h0000_00FF, "R2");
      bus_write(A_DIR_SET, 32'h0000_FF00);
      expect_read(A_DIR_ST, 32'h0000_FFFF, "R2");
      bus_write(A_DIR_CLR, 32'h0000_000F);
      expect_read(A_DIR_ST, 32'h0000_FFF0, "R2");
      bus_write(A_DAT_SET, 32'h0000_A5A5);
      expect_read(A_DAT_ST, 32'h0000_A5A5, "R2");
      // R3 bank-owned drive
      expect_port(K_OUT, 32'h0000_A5A5, "R3");
      expect_port(K_OE,  32'h0000_FFF0, "R3");
      // R4 peripheral ownership
      bus_write(A_OWN_CLR, 32'hFF00_0000);
      expect_read(A_OWN_ST, 32'h00FF_FFFF, "R4");
      expect_port(K_OUT, 32'h1200_A5A5, "R4");
      expect_port(K_OE,  32'hFF00_FFF0, "R4");
      bus_write(A_ALT, 32'h0F00_0000);
      expect_read(A_SEL_ST, 32'h0F00_0000, "R4");
      expect_port(K_OUT, 32'h1A00_A5A5, "R4");
      expect_port(K_OE,  32'hF000_FFF0, "R4");
      bus_write(A_PRI, 32'h0F00_0000);
      expect_read(A_SEL_ST, 32'h0, "R4");
      expect_port(K_OUT, 32'h1200_A5A5, "R4");
      // R5 open drain
      bus_write(A_OD_SET, 32'h0000_00FF);
      expect_port(K_OUT, 32'h1200_A500, "R5");
      expect_port(K_OE,  32'hFF00_FF50, "R5");
      bus_write(A_OD_CLR, 32'h0000_00FF);
      expect_port(K_OE,  32'hFF00_FFF0, "R5");
      // R6 pull-up
      bus_write(A_PU_CLR, 32'h0000_FFFF);
      expect_port(K_PU, 32'hFFFF_0000, "R6");
      bus_write(A_PU_SET, 32'h0000_0001);
      expect_read(A_PU_ST, 32'hFFFF_0001, "R6");
      expect_port(K_PU, 32'hFFFF_0001, "R6");
      // R7 unfiltered level, includes peripheral-owned pads
      @(negedge clk);
      pad_in = 32'h0F0F_0F0F;
      @(negedge clk);
      expect_read(A_LVL, 32'h0, "R7");
      @(negedge clk);
      expect_read(A_LVL, 32'h0F0F_0F0F, "R7");
      expect_port(K_LVL, 32'h0F0F_0F0F, "R7");
      // R8 filtered step
      bus_write(A_FLT_SET, 32'hFFFF_FFFF);
      expect_read(A_FLT_ST, 32'hFFFF_FFFF, "R8");
      pad_in = 32'hFFFF_FFFF;
      repeat (2) @(negedge clk);
      expect_port(K_LVL, 32'h0F0F_0F0F, "R8");
      @(negedge clk);
      expect_port(K_LVL, 32'hFFFF_FFFF, "R8");
      // R8 single-sample pulse rejected
      pad_in = 32'h0;
      @(negedge clk);
      pad_in = 32'hFFFF_FFFF;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         expect_port(K_LVL, 32'hFFFF_FFFF, "R8");
      end
      // R7 pulse passes where the filter is off
      bus_write(A_FLT_CLR, 32'hFFFF_0000);
      pad_in = 32'h0;
      @(negedge clk);
      pad_in = 32'hFFFF_FFFF;
      @(negedge clk);
      expect_read(A_LVL, 32'h0000_FFFF, "R7");
      @(negedge clk);
      expect_read(A_LVL, 32'hFFFF_FFFF, "R7");
      // R9 zero reads and ignored writes
      expect_read(A_DIR_SET, 32'h0, "R9");
      expect_read(A_PU_CLR,  32'h0, "R9");
      expect_read(8'hFC,     32'h0, "R9");
      expect_read(8'h1A,     32'h0, "R9");
      bus_write(A_DIR_ST, 32'hFFFF_FFFF);
      expect_read(A_DIR_ST, 32'h0000_FFF0, "R9");
      bus_write(A_LVL, 32'h0);
      expect_read(A_OWN_ST, 32'h00FF_FFFF, "R9");
      expect_port(K_OE, 32'hFF00_FFF0, "R9");
      done = 1'b1;
      finish_run();
   end
endmodule